// File: doc/BRIEF.md
# Parallel LCD Write-Bus Transmitter

This block is the sending side of an 8080-style parallel panel interface. A request carries one command word plus a count of trailing data words. The data words are either parameters or 16-bit colour pixels. The block cuts every word into bus beats, sending the most significant byte first. It drives the data/command select line with the configured level for each phase and frames the whole transfer with chip select. Each beat is strobed on a write line whose period is set by a prescale value.

Per-device settings arrive on static configuration inputs and are captured when a request is accepted. These settings are the two select-line levels, the chip-select polarity, the idle level of the write strobe, the colour byte swap and the prescale. Data words come from a valid/ready stream. If that stream runs dry at a beat boundary, the bus waits with the strobe idle. Only the 8-bit and 16-bit bus widths elaborate.

Top module: `lcd_wbus_tx`

## Requirements
- R1: While reset is held, and after it until the first request, chip select is at its inactive level (the inverse of `cfg_cs_hi_i`). The write strobe sits at its idle level. `lcd_data_o` and `lcd_dc_o` are 0, `done_o` and `err_o` are low and `req_ready_o` is high.
- R2: An accepted request sends the command first. The CMD_W-bit command is zero-extended to ceil(CMD_W/BUS_W) beats and sent most significant beat first, with `lcd_dc_o` equal to the captured command level.
- R3: With `req_kind_i` = 0, `req_len_i` parameter words follow the command. Each is PAR_W bits taken from the low bits of `dat_i`, zero-extended to whole beats and sent most significant beat first, with `lcd_dc_o` at the captured data level.
- R4: With `req_kind_i` = 1, `req_len_i` colour words follow the command. Each is taken from `dat_i[15:0]` and sent high byte first. When the swap setting is captured as 1, the two bytes are exchanged before sending.
- R5: Every beat lasts 2·P cycles, where P is the captured prescale. The strobe is at its active level for the first P cycles and at its idle level for the last P cycles.
- R6: The strobe idles high and is active low when `cfg_wr_idle_lo_i` = 0. It idles low and is active high when that input is 1.
- R7: While a transfer runs, `lcd_data_o` and `lcd_dc_o` change only in a cycle where the strobe has just entered its active level. They hold through the active-to-idle edge.
- R8: Chip select is at its active level (`cfg_cs_hi_i`) from the cycle after acceptance through the last idle cycle of the final beat. Otherwise it is inactive.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the last beat ends. `req_ready_o` is high only while no transfer runs, so a new request can be accepted in the `done_o` cycle.
- R10: `dat_ready_o` is high only at the end of a beat when a new data word is due. If `dat_valid_i` is low there, the strobe stays idle and the bus holds until a word arrives.
- R11: A request presented with prescale 0, or with a prescale above MAX_PRE, is consumed without any bus activity, and `err_o` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pre_i | input | PRE_W | Strobe prescale P (beat = 2·P cycles) |
| cfg_dc_cmd_i | input | 1 | Select-line level during the command phase |
| cfg_dc_dat_i | input | 1 | Select-line level during the data phase |
| cfg_cs_hi_i | input | 1 | Chip select is active high when 1 |
| cfg_wr_idle_lo_i | input | 1 | Strobe idles low when 1 |
| cfg_swap_i | input | 1 | Exchange the bytes of each colour word |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle; request taken when valid |
| req_cmd_i | input | CMD_W | Command word |
| req_kind_i | input | 1 | 0 parameters, 1 colour |
| req_len_i | input | LEN_W | Number of data words after the command |
| dat_valid_i | input | 1 | Data word present |
| dat_ready_o | output | 1 | Data word taken when valid |
| dat_i | input | max(PAR_W,16) | Data word |
| lcd_data_o | output | BUS_W | Panel data bus |
| lcd_wr_o | output | 1 | Write strobe |
| lcd_dc_o | output | 1 | Data/command select |
| lcd_cs_o | output | 1 | Chip select |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | One-cycle bad-prescale pulse |

## Verification
The bound assertions watch the properties that any single cycle can show. These are: data and select changing only as the strobe turns active, chip select framing the busy window, the single-cycle done and error pulses, and the bus freezing while a data word is missing. Beat order, byte swap, zero padding, the 2·P timing and the select level of each phase depend on word contents and on counting across many cycles. Only the behavioural reference model in the bench can show those, by comparing every output on every clock across several prescale values, polarities and stall patterns.

// File: rtl/lcd_wbus_pkg.sv
package lcd_wbus_pkg;
  typedef enum logic {
    KIND_PARAM = 1'b0,
    KIND_COLOR = 1'b1
  } wkind_e;

  function automatic int beats_of(int bits, int bus_w);
    return (bits + bus_w - 1) / bus_w;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_wbus_pace.sv
module lcd_wbus_pace #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == pre_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || (tick_o && !hold_i)) cnt_q <= '0;
    else if (run_i && !hold_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_wbus_pack.sv
module lcd_wbus_pack
  import lcd_wbus_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int PAR_W = 8,
  parameter int SW    = 16,
  parameter int BC_W  = 2,
  parameter int DW    = 16
) (
  input  logic [DW-1:0]   dat_i,
  input  wkind_e          kind_i,
  input  logic            swap_i,
  output logic [SW-1:0]   word_o,
  output logic [BC_W-1:0] last_o
);
  localparam int NP      = beats_of(PAR_W, BUS_W);
  localparam int PAR_PAD = NP * BUS_W;
  localparam int NK      = 16 / BUS_W;

  logic [PAR_PAD-1:0] par_pad;
  logic [15:0]        col;

  always_comb begin
    par_pad = PAR_PAD'(dat_i[PAR_W-1:0]);
    col     = swap_i ? {dat_i[7:0], dat_i[15:8]} : dat_i[15:0];
    if (kind_i == KIND_PARAM) begin
      word_o = SW'(par_pad) << (SW - PAR_PAD);
      last_o = BC_W'(NP - 1);
    end else begin
      word_o = SW'(col) << (SW - 16);
      last_o = BC_W'(NK - 1);
    end
  end
endmodule

// File: rtl/lcd_wbus_tx.sv
module lcd_wbus_tx
  import lcd_wbus_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int CMD_W   = 8,
  parameter int PAR_W   = 8,
  parameter int LEN_W   = 8,
  parameter int PRE_W   = 8,
  parameter int MAX_PRE = 255
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [PRE_W-1:0]                      cfg_pre_i,
  input  logic                                  cfg_dc_cmd_i,
  input  logic                                  cfg_dc_dat_i,
  input  logic                                  cfg_cs_hi_i,
  input  logic                                  cfg_wr_idle_lo_i,
  input  logic                                  cfg_swap_i,
  input  logic                                  req_valid_i,
  output logic                                  req_ready_o,
  input  logic [CMD_W-1:0]                      req_cmd_i,
  input  logic                                  req_kind_i,
  input  logic [LEN_W-1:0]                      req_len_i,
  input  logic                                  dat_valid_i,
  output logic                                  dat_ready_o,
  input  logic [((PAR_W > 16) ? PAR_W : 16)-1:0] dat_i,
  output logic [BUS_W-1:0]                      lcd_data_o,
  output logic                                  lcd_wr_o,
  output logic                                  lcd_dc_o,
  output logic                                  lcd_cs_o,
  output logic                                  done_o,
  output logic                                  err_o
);
  localparam int DW      = max2(PAR_W, 16);
  localparam int NC      = beats_of(CMD_W, BUS_W);
  localparam int NP      = beats_of(PAR_W, BUS_W);
  localparam int NK      = 16 / BUS_W;
  localparam int CMD_PAD = NC * BUS_W;
  localparam int SW      = max2(CMD_PAD, max2(NP * BUS_W, 16));
  localparam int BMAX    = max2(NC, max2(NP, NK));
  localparam int BC_W    = $clog2(BMAX + 1);
  localparam logic [PRE_W-1:0] MAX_PRE_V = PRE_W'(MAX_PRE);

  if (BUS_W != 8 && BUS_W != 16) begin : g_bad_width
    $error("lcd_wbus_tx: BUS_W must be 8 or 16");
  end

  logic              busy_q, act_q, dc_q, done_q, err_q;
  logic [SW-1:0]     sh_q;
  logic [BC_W-1:0]   bl_q;
  logic [LEN_W-1:0]  wl_q;
  logic [PRE_W-1:0]  pre_q;
  logic              dcd_q, csh_q, idlo_q, swap_q;
  wkind_e            kind_q;

  logic              tick, accept, bad_pre, boundary, need_word, stall;
  logic [SW-1:0]     cmd_al, pack_word;
  logic [BC_W-1:0]   pack_last;

  assign accept    = !busy_q && req_valid_i;
  assign bad_pre   = (cfg_pre_i == '0) || (cfg_pre_i > MAX_PRE_V);
  assign boundary  = busy_q && tick && !act_q;
  assign need_word = boundary && (bl_q == '0) && (wl_q != '0);
  assign stall     = need_word && !dat_valid_i;
  assign cmd_al    = SW'(CMD_PAD'(req_cmd_i)) << (SW - CMD_PAD);

  lcd_wbus_pace #(.PRE_W(PRE_W)) u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .clr_i  (accept),
    .hold_i (stall),
    .pre_i  (pre_q),
    .tick_o (tick)
  );

  lcd_wbus_pack #(
    .BUS_W(BUS_W), .PAR_W(PAR_W), .SW(SW), .BC_W(BC_W), .DW(DW)
  ) u_pack (
    .dat_i  (dat_i),
    .kind_i (kind_q),
    .swap_i (swap_q),
    .word_o (pack_word),
    .last_o (pack_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;  act_q  <= 1'b0;  dc_q   <= 1'b0;
      done_q <= 1'b0;  err_q  <= 1'b0;  sh_q   <= '0;
      bl_q   <= '0;    wl_q   <= '0;    pre_q  <= PRE_W'(1);
      dcd_q  <= 1'b0;  csh_q  <= 1'b0;  idlo_q <= 1'b0;
      swap_q <= 1'b0;  kind_q <= KIND_PARAM;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_pre) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          act_q  <= 1'b1;
          sh_q   <= cmd_al;
          bl_q   <= BC_W'(NC - 1);
          wl_q   <= req_len_i;
          dc_q   <= cfg_dc_cmd_i;
          pre_q  <= cfg_pre_i;
          dcd_q  <= cfg_dc_dat_i;
          csh_q  <= cfg_cs_hi_i;
          idlo_q <= cfg_wr_idle_lo_i;
          swap_q <= cfg_swap_i;
          kind_q <= wkind_e'(req_kind_i);
        end
      end else if (busy_q && tick) begin
        if (act_q) begin
          act_q <= 1'b0;
        end else if (bl_q != '0) begin
          sh_q  <= sh_q << BUS_W;
          bl_q  <= bl_q - 1'b1;
          act_q <= 1'b1;
        end else if (wl_q != '0) begin
          if (dat_valid_i) begin
            sh_q  <= pack_word;
            bl_q  <= pack_last;
            wl_q  <= wl_q - 1'b1;
            dc_q  <= dcd_q;
            act_q <= 1'b1;
          end
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // active strobe level is the inverse of the idle level
  assign lcd_wr_o    = busy_q ? (act_q ? idlo_q : !idlo_q) : !cfg_wr_idle_lo_i;
  assign lcd_cs_o    = busy_q ? csh_q : !cfg_cs_hi_i;
  assign lcd_data_o  = sh_q[SW-1 -: BUS_W];
  assign lcd_dc_o    = dc_q;
  assign req_ready_o = !busy_q;
  assign dat_ready_o = need_word;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/lcd_wbus_tx_chk.sv
module lcd_wbus_tx_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_cs_hi_i,
  input logic             cfg_wr_idle_lo_i,
  input logic             req_ready_o,
  input logic             dat_valid_i,
  input logic             dat_ready_o,
  input logic [BUS_W-1:0] lcd_data_o,
  input logic             lcd_wr_o,
  input logic             lcd_dc_o,
  input logic             lcd_cs_o,
  input logic             done_o,
  input logic             err_o
);
  p_change_on_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o) && !($stable(lcd_data_o) && $stable(lcd_dc_o)))
      |-> (lcd_wr_o == cfg_wr_idle_lo_i && $past(lcd_wr_o) != cfg_wr_idle_lo_i));

  p_cs_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> lcd_cs_o == cfg_cs_hi_i);

  p_cs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> lcd_cs_o != cfg_cs_hi_i);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  p_dready_idle_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_ready_o |-> (!req_ready_o && lcd_wr_o != cfg_wr_idle_lo_i));

  p_stall_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_ready_o && !dat_valid_i) |=> (lcd_wr_o == $past(lcd_wr_o) && $stable(lcd_data_o)));

  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (req_ready_o && !done_o));
endmodule

bind lcd_wbus_tx lcd_wbus_tx_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_cs_hi_i      (cfg_cs_hi_i),
  .cfg_wr_idle_lo_i (cfg_wr_idle_lo_i),
  .req_ready_o      (req_ready_o),
  .dat_valid_i      (dat_valid_i),
  .dat_ready_o      (dat_ready_o),
  .lcd_data_o       (lcd_data_o),
  .lcd_wr_o         (lcd_wr_o),
  .lcd_dc_o         (lcd_dc_o),
  .lcd_cs_o         (lcd_cs_o),
  .done_o           (done_o),
  .err_o            (err_o)
);

// File: tb/lcd_wbus_tx_tb_top.sv
module lcd_wbus_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W   = 8;
  localparam int CMD_W   = 16;
  localparam int PAR_W   = 24;
  localparam int LEN_W   = 4;
  localparam int PRE_W   = 4;
  localparam int MAX_PRE = 8;
  localparam int DW      = 24;

  logic clk, rst_n;
  logic [PRE_W-1:0] cfg_pre;
  logic cfg_dc_cmd, cfg_dc_dat, cfg_cs_hi, cfg_idle_lo, cfg_swap;
  logic req_valid, req_ready, req_kind;
  logic [CMD_W-1:0] req_cmd;
  logic [LEN_W-1:0] req_len;
  logic dat_valid, dat_ready;
  logic [DW-1:0] dat;
  logic [BUS_W-1:0] lcd_data;
  logic lcd_wr, lcd_dc, lcd_cs, done, err;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  lcd_wbus_tx #(
    .BUS_W(BUS_W), .CMD_W(CMD_W), .PAR_W(PAR_W), .LEN_W(LEN_W),
    .PRE_W(PRE_W), .MAX_PRE(MAX_PRE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pre_i(cfg_pre),
    .cfg_dc_cmd_i(cfg_dc_cmd), .cfg_dc_dat_i(cfg_dc_dat),
    .cfg_cs_hi_i(cfg_cs_hi), .cfg_wr_idle_lo_i(cfg_idle_lo), .cfg_swap_i(cfg_swap),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cmd_i(req_cmd),
    .req_kind_i(req_kind), .req_len_i(req_len),
    .dat_valid_i(dat_valid), .dat_ready_o(dat_ready), .dat_i(dat),
    .lcd_data_o(lcd_data), .lcd_wr_o(lcd_wr), .lcd_dc_o(lcd_dc), .lcd_cs_o(lcd_cs),
    .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus stream for data words
  logic [DW-1:0] stim_q[$];
  bit stall_en = 0;
  int stall_ph = 0;
  always @(negedge clk) begin
    stall_ph++;
    dat_valid = (stim_q.size() > 0) && (!stall_en || (stall_ph % 3 == 0));
    dat       = (stim_q.size() > 0) ? stim_q[0] : '0;
  end

  // behavioural reference model
  logic [BUS_W-1:0] m_qd[$];
  bit m_busy, m_act, m_done, m_err, m_dc, m_dcd, m_csh, m_idlo, m_swap, m_kind;
  int m_cnt, m_pre, m_words;
  logic [BUS_W-1:0] m_data;

  function automatic void push_beats(logic [31:0] w, int bits);
    int nb = (bits + BUS_W - 1) / BUS_W;
    for (int i = nb - 1; i >= 0; i--) m_qd.push_back(BUS_W'(w >> (i * BUS_W)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_act = 0; m_done = 0; m_err = 0; m_dc = 0; m_data = '0;
      m_cnt = 0; m_pre = 1; m_words = 0; m_dcd = 0; m_csh = 0; m_idlo = 0;
      m_swap = 0; m_kind = 0; m_qd.delete();
    end else begin
      m_done = 0; m_err = 0;
      if (!m_busy) begin
        if (req_valid) begin
          if (cfg_pre == 0 || int'(cfg_pre) > MAX_PRE) m_err = 1;
          else begin
            m_pre = int'(cfg_pre); m_dcd = cfg_dc_dat; m_csh = cfg_cs_hi;
            m_idlo = cfg_idle_lo; m_swap = cfg_swap; m_kind = req_kind;
            m_words = int'(req_len);
            push_beats(32'(req_cmd), CMD_W);
            m_dc = cfg_dc_cmd; m_data = m_qd.pop_front();
            m_act = 1; m_cnt = 0; m_busy = 1;
          end
        end
      end else if (m_cnt == m_pre - 1) begin
        if (m_act) begin
          m_act = 0; m_cnt = 0;
        end else if (m_qd.size() > 0) begin
          m_data = m_qd.pop_front(); m_act = 1; m_cnt = 0;
        end else if (m_words > 0) begin
          if (dat_valid) begin
            logic [DW-1:0] w;
            w = stim_q.pop_front();
            if (m_kind) push_beats(32'(m_swap ? {w[7:0], w[15:8]} : w[15:0]), 16);
            else        push_beats(32'(w), PAR_W);
            m_dc = m_dcd; m_data = m_qd.pop_front();
            m_words--; m_act = 1; m_cnt = 0;
          end
        end else begin
          m_busy = 0; m_done = 1;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check(string req, string name, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, name, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic e_wr, e_cs, e_dr;
      e_wr = m_busy ? (m_act ? m_idlo : !m_idlo) : !cfg_idle_lo;
      e_cs = m_busy ? m_csh : !cfg_cs_hi;
      e_dr = m_busy && !m_act && (m_cnt == m_pre - 1) && (m_qd.size() == 0) && (m_words > 0);
      check("R2/R3/R4", "lcd_data_o", 32'(lcd_data), 32'(m_data));
      check("R5/R6", "lcd_wr_o", 32'(lcd_wr), 32'(e_wr));
      check("R7", "lcd_dc_o", 32'(lcd_dc), 32'(m_dc));
      check("R8", "lcd_cs_o", 32'(lcd_cs), 32'(e_cs));
      check("R9", "done_o", 32'(done), 32'(m_done));
      check("R9", "req_ready_o", 32'(req_ready), 32'(!m_busy));
      check("R10", "dat_ready_o", 32'(dat_ready), 32'(e_dr));
      check("R11", "err_o", 32'(err), 32'(m_err));
    end
  end

  task automatic txn(input int pre, input logic dcc, input logic dcd, input logic csh,
                     input logic idlo, input logic swp, input logic kind,
                     input logic [CMD_W-1:0] cmd, input int len);
    while (!req_ready) @(negedge clk);
    cfg_pre = PRE_W'(pre); cfg_dc_cmd = dcc; cfg_dc_dat = dcd; cfg_cs_hi = csh;
    cfg_idle_lo = idlo; cfg_swap = swp;
    req_kind = kind; req_cmd = cmd; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_kind = 1'b0; req_len = '0;
    cfg_pre = PRE_W'(1); cfg_dc_cmd = 1'b0; cfg_dc_dat = 1'b1; cfg_cs_hi = 1'b0;
    cfg_idle_lo = 1'b0; cfg_swap = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1", "reset cs", 32'(lcd_cs), 32'd1);
    check("R1", "reset wr", 32'(lcd_wr), 32'd1);
    check("R1", "reset data", 32'(lcd_data), 32'd0);
    check("R1", "reset dc", 32'(lcd_dc), 32'd0);
    check("R1", "reset done/err", 32'({done, err}), 32'd0);
    check("R1", "reset ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: command only, two beats, P=1
    txn(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA55A, 0);
    // R3: two 24-bit parameters, P=2
    stim_q.push_back(24'h123456); stim_q.push_back(24'hABCDEF);
    txn(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2C01, 2);
    // R4 R6 R8: colour, strobe idle low, CS active high, P=3
    stim_q.push_back(24'h00F800); stim_q.push_back(24'h0007E0); stim_q.push_back(24'h001234);
    txn(3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h002C, 3);
    // R4 R10: swapped colour with a stalling stream
    stall_en = 1;
    stim_q.push_back(24'h00BEEF); stim_q.push_back(24'h000102);
    txn(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h3C3C, 2);
    stall_en = 0;
    // R11: bad prescales
    txn(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1111, 0);
    txn(9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222, 0);
    // R5: maximum prescale, equal DC levels
    stim_q.push_back(24'h00FF00);
    txn(MAX_PRE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h00FF, 1);
    // R9: back-to-back requests, second taken in the done cycle
    txn(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 0);
    txn(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7FFE, 0);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule